// File: doc/BRIEF.md
# ATM Cell Egress Byte Transmitter

This block moves ATM cells from a user-side word source onto an 8-bit cell-level handshake port toward a link-layer master. Cells sit in the source as 27 words of 16 bits each. The block fetches them with a one-cycle read strobe and a word address, then sends each word as two bytes with the upper half first. It raises start-of-cell on the first header byte. It drives cell-available toward the master, and that signal follows the source's "complete cell ready" flag. Everything runs on one clock.

Two cell lengths are supported. In the 54-byte mode every byte of the stored cell is sent. In the 53-byte mode the sixth byte is never sent, which is the second user-defined header byte. To keep the byte stream free of gaps, the read strobe normally has a one-cycle rest after each word. That rest is skipped once per cell in the 53-byte mode, so the word that holds the first payload byte is already in hand when it is needed.

Back-pressure works only at cell boundaries. The master holds an active-low enable. The source holds a ready flag. Both are sampled when a cell may start, and again while the second-to-last byte of a cell is on the bus. Once a cell has begun it cannot be stalled. The source must present the addressed word in the same cycle the strobe is high.

Top module: `atm_egress_tx`

## Requirements
- R1: `clav` equals the value `cell_rdy` had at the previous clock edge, and is low after reset.
- R2: From idle, if a clock edge samples `lnk_en_n` low and `cell_rdy` high, two things follow. In the next cycle `rd_en` is high with `rd_addr` = 0. In the cycle after that, `soc` is high and `dout` carries the first header byte.
- R3: Each word is split into two bytes. Bits 15:8 go out first and bits 7:0 go out second.
- R4: A word is read by holding `rd_en` high for one cycle, and `rd_data` is taken at the edge that ends that cycle. Two reads fall in adjacent cycles only for words 2 and 3.
- R5: With `full_cell` = 0 the cell is 53 bytes long, and byte index 5 of the stored cell (the low half of word 2) is never sent. With `full_cell` = 1 all 54 bytes are sent.
- R6: Once a cell has started, all of its bytes appear one per cycle with no gap, whatever `cell_rdy` and `lnk_en_n` do.
- R7: Suppose the edge that ends the cycle carrying the second-to-last byte samples `lnk_en_n` low and `cell_rdy` high. Then the next cell's first byte, with `soc` high, follows the last byte in the very next cycle.
- R8: If the condition in R7 does not hold, the port is idle after the last byte: `dout` = 0, `soc` = 0, `rd_en` = 0. This holds even when `lnk_en_n` stays low.
- R9: `full_cell` is sampled at the edge that decides a cell start, and it governs that whole cell.
- R10: A synchronous active-high `rst` clears the address, the sequencing state and all outputs, including mid-cell.
- R11: `rd_addr` counts words 0 to 26 within a cell and starts again at 0 for the next cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous reset, active high |
| full_cell | input | 1 | 1 = 54-byte cells, 0 = 53-byte cells |
| cell_rdy | input | 1 | Source holds at least one complete cell |
| rd_en | output | 1 | Word read strobe toward the source |
| rd_addr | output | 5 | Word index within the cell |
| rd_data | input | 16 | Addressed word, valid while `rd_en` is high |
| lnk_en_n | input | 1 | Link-layer enable, active low |
| clav | output | 1 | Cell available toward the link layer |
| soc | output | 1 | Start-of-cell, high with the first header byte |
| dout | output | 8 | Byte stream toward the link layer |

## Verification
The assertions take for granted that the source presents `rd_data` combinationally from `rd_addr` while `rd_en` is high. They also assume that `lnk_en_n`, `cell_rdy` and `full_cell` change only between clock edges. The stimulus drives every input one time step after a rising edge, and it models the source as a pure function of the address and a cell counter that advances on each read of word 26. The random phase changes the enable, the ready flag and the mode at arbitrary points, including in the middle of cells. This exercises the rule that these inputs matter only at start and continuation edges.

// File: rtl/atm_tx_pkg.sv
package atm_tx_pkg;
  localparam int unsigned ATM_CELL_WORDS = 27;
  localparam int unsigned ATM_DROP_IDX   = 5;
  localparam int unsigned ATM_WORD_W     = 16;

  // Successor of a byte index inside one cell; the dropped byte is stepped over
  function automatic int unsigned step_idx(int unsigned cur, int unsigned drop, logic full);
    if (!full && cur == drop - 1) return drop + 1;
    return cur + 1;
  endfunction
endpackage

// File: rtl/atm_tx_seq.sv
module atm_tx_seq
  import atm_tx_pkg::*;
#(
  parameter int unsigned CELL_WORDS = ATM_CELL_WORDS,
  parameter int unsigned DROP_IDX   = ATM_DROP_IDX,
  localparam int unsigned BI_W      = $clog2(2 * CELL_WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            full_cell,
  input  logic            cell_rdy,
  input  logic            lnk_en_n,
  output logic            nxt_vld,
  output logic [BI_W-1:0] nxt_idx
);
  localparam logic [BI_W-1:0] LAST_IDX = BI_W'(2 * CELL_WORDS - 1);

  logic            cur_vld, start_q, cont_q, full_q;
  logic [BI_W-1:0] cur_idx;
  logic            go, idle_go, enter_last;

  assign go         = !lnk_en_n && cell_rdy;
  assign idle_go    = !start_q && !cur_vld && go;
  assign enter_last = cur_vld && nxt_vld && (nxt_idx == LAST_IDX);

  always_comb begin
    nxt_vld = 1'b0;
    nxt_idx = '0;
    if (start_q) begin
      nxt_vld = 1'b1;
    end else if (cur_vld) begin
      if (cur_idx == LAST_IDX) begin
        nxt_vld = cont_q;
      end else begin
        nxt_vld = 1'b1;
        nxt_idx = BI_W'(step_idx(int'(cur_idx), DROP_IDX, full_q));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_vld <= 1'b0;
      cur_idx <= '0;
      start_q <= 1'b0;
      cont_q  <= 1'b0;
      full_q  <= 1'b1;
    end else begin
      cur_vld <= nxt_vld;
      cur_idx <= nxt_idx;
      start_q <= idle_go;
      if (idle_go) full_q <= full_cell;
      if (enter_last) begin
        cont_q <= go;
        if (go) full_q <= full_cell;
      end
    end
  end
endmodule

// File: rtl/atm_tx_unpack.sv
module atm_tx_unpack
  import atm_tx_pkg::*;
#(
  parameter int unsigned WORD_W     = ATM_WORD_W,
  parameter bit          UPPER_FIRST = 1'b1,
  localparam int unsigned BYTE_W    = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch,
  input  logic              nxt_vld,
  input  logic              nxt_first,
  input  logic [WORD_W-1:0] rd_data,
  output logic              soc,
  output logic [BYTE_W-1:0] dout
);
  logic [BYTE_W-1:0] first_b, second_b, hold_q;

  generate
    if (UPPER_FIRST) begin : g_upper
      assign first_b  = rd_data[WORD_W-1:BYTE_W];
      assign second_b = rd_data[BYTE_W-1:0];
    end else begin : g_lower
      assign first_b  = rd_data[BYTE_W-1:0];
      assign second_b = rd_data[WORD_W-1:BYTE_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      dout   <= '0;
      hold_q <= '0;
      soc    <= 1'b0;
    end else begin
      soc <= nxt_vld && nxt_first;
      if (fetch) begin
        dout   <= first_b;
        hold_q <= second_b;
      end else if (nxt_vld) begin
        dout <= hold_q;
      end else begin
        dout <= '0;
      end
    end
  end
endmodule

// File: rtl/atm_egress_tx.sv
module atm_egress_tx
  import atm_tx_pkg::*;
#(
  parameter int unsigned CELL_WORDS = ATM_CELL_WORDS,
  parameter int unsigned DROP_IDX   = ATM_DROP_IDX,
  parameter int unsigned WORD_W     = ATM_WORD_W,
  localparam int unsigned BI_W      = $clog2(2 * CELL_WORDS),
  localparam int unsigned ADDR_W    = BI_W - 1,
  localparam int unsigned BYTE_W    = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              full_cell,
  input  logic              cell_rdy,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] rd_data,
  input  logic              lnk_en_n,
  output logic              clav,
  output logic              soc,
  output logic [BYTE_W-1:0] dout
);
  logic            nxt_vld;
  logic [BI_W-1:0] nxt_idx;

  atm_tx_seq #(.CELL_WORDS(CELL_WORDS), .DROP_IDX(DROP_IDX)) u_seq (
    .clk(clk), .rst(rst), .full_cell(full_cell), .cell_rdy(cell_rdy),
    .lnk_en_n(lnk_en_n), .nxt_vld(nxt_vld), .nxt_idx(nxt_idx)
  );

  // An even next byte index is the first half of a word: fetch it now
  assign rd_en   = nxt_vld && !nxt_idx[0];
  assign rd_addr = nxt_idx[BI_W-1:1];

  atm_tx_unpack #(.WORD_W(WORD_W), .UPPER_FIRST(1'b1)) u_unpack (
    .clk(clk), .rst(rst), .fetch(rd_en), .nxt_vld(nxt_vld),
    .nxt_first(nxt_idx == '0), .rd_data(rd_data), .soc(soc), .dout(dout)
  );

  always_ff @(posedge clk) begin
    if (rst) clav <= 1'b0;
    else     clav <= cell_rdy;
  end
endmodule

// File: rtl/atm_tx_chk.sv
module atm_tx_chk #(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned LAST_WORD = 26
) (
  input logic              clk,
  input logic              rst,
  input logic              cell_rdy,
  input logic              clav,
  input logic              soc,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [BYTE_W-1:0] dout
);
  AST_CLAV_TRACKS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> clav == $past(cell_rdy)); // R1

  AST_SOC_AFTER_WORD0: assert property (@(posedge clk) disable iff (rst)
    soc |-> $past(rd_en) && $past(rd_addr) == '0); // R2

  AST_SOC_SINGLE: assert property (@(posedge clk) disable iff (rst)
    soc |=> !soc); // R6

  AST_PAIRED_READS: assert property (@(posedge clk) disable iff (rst)
    rd_en && $past(rd_en) && !$past(rst) |-> rd_addr == ADDR_W'(3) && $past(rd_addr) == ADDR_W'(2)); // R4

  AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> rd_addr <= ADDR_W'(LAST_WORD)); // R11

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> dout == '0 && !soc && !rd_en && !clav); // R10
endmodule

bind atm_egress_tx atm_tx_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .LAST_WORD(CELL_WORDS - 1)) u_chk (
  .clk(clk), .rst(rst), .cell_rdy(cell_rdy), .clav(clav), .soc(soc),
  .rd_en(rd_en), .rd_addr(rd_addr), .dout(dout)
);

// File: tb/sim_atm_egress_tx.sv
module sim_atm_egress_tx;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, full_cell = 1'b1, cell_rdy = 1'b0, lnk_en_n = 1'b1;
  logic rd_en, clav, soc;
  logic [4:0]  rd_addr;
  logic [15:0] rd_data;
  logic [7:0]  dout;

  int checks = 0, errors = 0, tag = 0;
  string ph = "R10 reset";

  function automatic logic [15:0] src_word(int t, int w);
    logic [7:0] h, l;
    h = 8'(t * 37 + w * 5 + 1);
    l = 8'(t * 11 + w * 3 + 128);
    return {h, l};
  endfunction

  function automatic int bmap(int pos, bit m);
    return (!m && pos >= 5) ? pos + 1 : pos;   // R5: byte 5 skipped in 53-byte mode
  endfunction

  function automatic logic [7:0] exp_byte(int t, int bi);
    logic [15:0] w;
    w = src_word(t, bi / 2);
    return (bi % 2 == 0) ? w[15:8] : w[7:0];   // R3: upper half first
  endfunction

  assign rd_data = src_word(tag, int'(rd_addr));
  always @(posedge clk) begin
    if (rst) tag <= 0;
    else if (rd_en && rd_addr == 5'd26) tag <= tag + 1;
  end

  atm_egress_tx u0 (
    .clk(clk), .rst(rst), .full_cell(full_cell), .cell_rdy(cell_rdy),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .lnk_en_n(lnk_en_n),
    .clav(clav), .soc(soc), .dout(dout)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s) act=%0h exp=%0h", req, ph, act, exp);
    end
  endtask

  int st = 0, p = 0, cellk = 0;
  bit m54 = 1, nm54 = 1, cont = 0, prev_rdy = 0, rst_prev = 1;

  always @(negedge clk) begin
    automatic logic [7:0] e_d = '0;
    automatic bit e_soc = 0, e_rd = 0, go;
    automatic int e_addr = 0, nbi, lastp;
    lastp = m54 ? 53 : 52;
    if (st == 1) begin
      e_rd = 1;
    end else if (st == 2) begin
      e_d   = exp_byte(cellk, bmap(p, m54));
      e_soc = (p == 0);
      if (p < lastp) begin
        nbi = bmap(p + 1, m54);
        if (nbi % 2 == 0) begin e_rd = 1; e_addr = nbi / 2; end
      end else if (cont) begin
        e_rd = 1;
      end
    end
    chk(clav == prev_rdy, "R1 clav", clav, prev_rdy);
    chk(soc == e_soc, "R2/R7 soc", soc, e_soc);
    chk(dout == e_d, (st == 2) ? (m54 ? "R3/R6 byte" : "R5/R9 byte") : "R8 idle byte", dout, e_d);
    chk(rd_en == e_rd, "R4 rd_en", rd_en, e_rd);
    if (e_rd) chk(int'(rd_addr) == e_addr, "R11 rd_addr", rd_addr, e_addr);
    if (rst_prev) chk(rd_addr == 5'd0, "R10 reset addr", rd_addr, 0);

    go = !lnk_en_n && cell_rdy;
    if (rst) begin
      st = 0; p = 0; cellk = 0; cont = 0; prev_rdy = 0;
    end else begin
      prev_rdy = cell_rdy;
      case (st)
        0: if (go) begin st = 1; m54 = full_cell; end
        1: begin st = 2; p = 0; end
        default: begin
          if (p == lastp - 1) begin
            cont = go;
            if (go) nm54 = full_cell;
            p++;
          end else if (p == lastp) begin
            cellk++;
            if (cont) begin p = 0; m54 = nm54; end
            else st = 0;
          end else begin
            p++;
          end
        end
      endcase
    end
    rst_prev = rst;
  end

  task automatic step(int n, bit en_n_v, bit rdy_v, bit m);
    lnk_en_n = en_n_v; cell_rdy = rdy_v; full_cell = m;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (%s) act=%0d exp=%0d", ph, 200000, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'h1d5e_a7c3));
    lnk_en_n = 1'b0; cell_rdy = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    ph = "R6 single 54-byte cell, inputs dropped";
    step(3, 0, 1, 1); step(70, 1, 0, 1);
    ph = "R9 53-byte cell, mode flipped mid-cell";
    step(3, 0, 1, 0); step(70, 1, 0, 1);
    ph = "R7 back-to-back 54";
    step(170, 0, 1, 1);
    ph = "R7 back-to-back 53";
    step(170, 0, 1, 0);
    ph = "R8 ready low with enable held";
    step(5, 0, 1, 1); step(120, 0, 0, 1);
    ph = "R10 reset mid-cell";
    step(20, 0, 1, 1);
    rst = 1'b1; step(2, 0, 1, 1);
    rst = 1'b0; step(70, 1, 0, 1);
    ph = "R4 random mix";
    for (int i = 0; i < 6000; i++)
      step(1 + int'($urandom % 8), ($urandom % 4) == 0, ($urandom % 3) != 0, $urandom % 2);
    step(80, 1, 0, 1);
    finish_run();
  end
endmodule